// File: doc/BRIEF.md
# Two-Master Credit-Share Arbiter

This block puts one pipelined memory slave port in front of two masters. One master only fetches instructions and so only reads. The other master handles data and both reads and writes. When the grant goes to a master, that master keeps the slave for a run of accepted word transfers. The length of the run is set by the master's own share credit. A cache line can therefore cross the port as one unbroken run. Without the credit, the two requesters would trade the slave after every word, and the memory behind the port would have to close and reopen rows each time.

Each master presents its address, its command, and (for the data master) its write data and byte enables. It holds these stable while its waitrequest is high. The arbiter routes the granted master's command to the slave. The slave may return read data several cycles later and may have many reads in flight. For each accepted read, the arbiter stores the identity of the master that issued it. It uses this record to send every returning read-data-valid pulse to the master that asked for it.

Top module: `dual_credit_arbiter`

## Requirements
- R1: After reset, while neither master requests, both waitrequest outputs are high and slave read, slave write and both read-data-valid outputs are low.
- R2: Only one master is granted at a time. The slave sees the granted master's address, command, write data and byte enables. The instruction master always presents all byte enables set. No slave command is issued without a grant.
- R3: A master's waitrequest is low in exactly the cycles in which its transfer is accepted. A transfer is accepted when the master is granted and requesting, slave waitrequest is low, and the transfer is not a read blocked by a full pending-read record. Waitrequest is high at all other times.
- R4: A credit input of 0 to 15 sets how many accepted transfers a master may make per grant. The value 0 counts as 1. While a master keeps requesting, it keeps the grant until its credit is used up, even if the other master is waiting.
- R5: The grant is decided again after the credit runs out or after the holder stops requesting. A grant that the slave stalls stays with its master until the transfer is accepted.
- R6: When both masters compete for a new grant, the master that did not make the last accepted transfer wins. After reset, the instruction master wins the first tie.
- R7: A lone requester is granted in the same cycle it raises its request, with no idle cycle.
- R8: Read returns are delivered in issue order to the master that issued each read. At most one read-data-valid output is high in a cycle. Read data passes to both masters unchanged.
- R9: At most 8 reads may be pending. When 8 are pending, further reads are held off with waitrequest high until a read returns. Writes are still accepted in that state.
- R10: With credit 1 on both masters and both requesting continuously, accepted transfers alternate one word at a time. With credit 8 on both, each master moves 8 words before the grant switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instrCredit | input | 4 | Share credit for the instruction master (0 treated as 1) |
| dataCredit | input | 4 | Share credit for the data master (0 treated as 1) |
| instrAddr | input | 32 | Instruction master address |
| instrRead | input | 1 | Instruction master read request |
| instrWait | output | 1 | Instruction master waitrequest |
| instrRdata | output | 32 | Read data to instruction master |
| instrRvalid | output | 1 | Read data valid to instruction master |
| dataAddr | input | 32 | Data master address |
| dataRead | input | 1 | Data master read request |
| dataWrite | input | 1 | Data master write request |
| dataWdata | input | 32 | Data master write data |
| dataByteEn | input | 4 | Data master byte enables |
| dataWait | output | 1 | Data master waitrequest |
| dataRdata | output | 32 | Read data to data master |
| dataRvalid | output | 1 | Read data valid to data master |
| memAddr | output | 32 | Slave address |
| memRead | output | 1 | Slave read command |
| memWrite | output | 1 | Slave write command |
| memWdata | output | 32 | Slave write data |
| memByteEn | output | 4 | Slave byte enables |
| memWait | input | 1 | Slave waitrequest |
| memRdata | input | 32 | Slave read data |
| memRvalid | input | 1 | Slave read data valid |

## Verification
Two functions can land in the same cycle. A read return can pop the pending-read record in the cycle a new read is being accepted, and this matters most when the record is full. A return can also be steered to one master in the very cycle the grant passes to the other master. Both cases are provoked with a slave whose read latency is longer than the record depth, and with random slave stalls while both masters fight over mixed traffic. A behavioural model in the bench judges the outcome on every clock: it predicts each waitrequest, each slave command and each return destination. Directed runs also compare the sequence of accepted transfers against the order that R4, R5, R6 and R10 require.

// File: rtl/credit_arb_pkg.sv
package credit_arb_pkg;

  // identity of a master; also stored per pending read
  typedef enum logic {
    MST_INSTR = 1'b0,
    MST_DATA  = 1'b1
  } mst_e;

  // strobes from control to datapath
  typedef struct packed {
    logic grantValid;  // some master holds the grant this cycle
    mst_e grantId;     // which one
    logic accept;      // granted transfer completes at this edge
  } arbStrobe_t;

endpackage

// File: rtl/dca_control.sv
module dca_control
  import credit_arb_pkg::*;
#(
  parameter int CREDIT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CREDIT_W-1:0] instrCredit,
  input  logic [CREDIT_W-1:0] dataCredit,
  input  logic                instrRead,
  input  logic                dataRead,
  input  logic                dataWrite,
  input  logic                memWait,
  input  logic                fifoFull,
  output arbStrobe_t          strobe
);

  localparam logic [CREDIT_W-1:0] ONE_CREDIT = CREDIT_W'(1);

  logic                locked, lockedNext;
  mst_e                owner, ownerNext;
  mst_e                lastOwner, lastOwnerNext;
  logic [CREDIT_W-1:0] creditLeft, creditLeftNext;

  logic                instrReq, dataReq, ownerReq, hold;
  logic                grantValid, readSel, accept;
  mst_e                grantId;
  logic [CREDIT_W-1:0] cfgCredit, baseCredit, remaining;

  // request view and grant choice
  always_comb begin
    instrReq = instrRead;
    dataReq  = dataRead | dataWrite;
    ownerReq = (owner == MST_DATA) ? dataReq : instrReq;
    hold     = locked && ownerReq;

    grantValid = instrReq || dataReq;
    if (hold)
      grantId = owner;
    else if (instrReq && dataReq)
      grantId = (lastOwner == MST_DATA) ? MST_INSTR : MST_DATA;
    else if (dataReq)
      grantId = MST_DATA;
    else
      grantId = MST_INSTR;

    readSel = (grantId == MST_DATA) ? dataRead : instrRead;
    accept  = grantValid && !memWait && !(readSel && fifoFull);
  end

  // credit bookkeeping
  always_comb begin
    cfgCredit = (grantId == MST_DATA) ? dataCredit : instrCredit;
    if (cfgCredit == '0)
      cfgCredit = ONE_CREDIT;
    baseCredit = hold ? creditLeft : cfgCredit;
    remaining  = baseCredit - ONE_CREDIT;

    lockedNext     = locked;
    ownerNext      = owner;
    lastOwnerNext  = lastOwner;
    creditLeftNext = creditLeft;

    if (!grantValid) begin
      lockedNext = 1'b0;
    end else if (accept) begin
      lockedNext     = (remaining != '0);
      ownerNext      = grantId;
      lastOwnerNext  = grantId;
      creditLeftNext = remaining;
    end else begin
      // stalled: keep this master until its transfer goes through
      lockedNext     = 1'b1;
      ownerNext      = grantId;
      creditLeftNext = baseCredit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked     <= 1'b0;
      owner      <= MST_INSTR;
      lastOwner  <= MST_DATA;
      creditLeft <= '0;
    end else begin
      locked     <= lockedNext;
      owner      <= ownerNext;
      lastOwner  <= lastOwnerNext;
      creditLeft <= creditLeftNext;
    end
  end

  always_comb begin
    strobe.grantValid = grantValid;
    strobe.grantId    = grantId;
    strobe.accept     = accept;
  end

endmodule

// File: rtl/dca_datapath.sv
module dca_datapath
  import credit_arb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PEND_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arbStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    instrAddr,
  input  logic                 instrRead,
  output logic                 instrWait,
  output logic [DATA_W-1:0]    instrRdata,
  output logic                 instrRvalid,
  input  logic [ADDR_W-1:0]    dataAddr,
  input  logic                 dataRead,
  input  logic                 dataWrite,
  input  logic [DATA_W-1:0]    dataWdata,
  input  logic [DATA_W/8-1:0]  dataByteEn,
  output logic                 dataWait,
  output logic [DATA_W-1:0]    dataRdata,
  output logic                 dataRvalid,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memRead,
  output logic                 memWrite,
  output logic [DATA_W-1:0]    memWdata,
  output logic [DATA_W/8-1:0]  memByteEn,
  input  logic [DATA_W-1:0]    memRdata,
  input  logic                 memRvalid,
  output logic                 fifoFull
);

  localparam int PTR_W = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;
  localparam int CNT_W = $clog2(PEND_DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PEND_DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(PEND_DEPTH - 1);
  localparam bit DEPTH_POW2 = ((PEND_DEPTH & (PEND_DEPTH - 1)) == 0);

  logic selInstr, selData, push, pop;
  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrNext, rdPtrNext;
  logic [CNT_W-1:0] pendCnt;
  mst_e idMem [PEND_DEPTH];
  mst_e headId;

  // command steering
  always_comb begin
    selInstr = strobe.grantValid && (strobe.grantId == MST_INSTR);
    selData  = strobe.grantValid && (strobe.grantId == MST_DATA);

    memAddr   = selData ? dataAddr : instrAddr;
    memWrite  = selData && dataWrite;
    memRead   = ((selInstr && instrRead) || (selData && dataRead)) && !fifoFull;
    memWdata  = dataWdata;
    memByteEn = selData ? dataByteEn : '1;

    instrWait = !(strobe.accept && selInstr);
    dataWait  = !(strobe.accept && selData);
  end

  // pending-read record of issuing master
  assign fifoFull = (pendCnt == CNT_MAX);
  assign push     = strobe.accept && memRead;
  assign pop      = memRvalid && (pendCnt != '0);

  generate
    if (DEPTH_POW2) begin : g_ptrPow2
      assign wrPtrNext = wrPtr + PTR_W'(1);
      assign rdPtrNext = rdPtr + PTR_W'(1);
    end else begin : g_ptrWrap
      assign wrPtrNext = (wrPtr == PTR_LAST) ? '0 : wrPtr + PTR_W'(1);
      assign rdPtrNext = (rdPtr == PTR_LAST) ? '0 : rdPtr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push)
      idMem[wrPtr] <= strobe.grantId;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      pendCnt <= '0;
    end else begin
      if (push) wrPtr <= wrPtrNext;
      if (pop)  rdPtr <= rdPtrNext;
      case ({push, pop})
        2'b10:   pendCnt <= pendCnt + CNT_W'(1);
        2'b01:   pendCnt <= pendCnt - CNT_W'(1);
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  // return routing
  always_comb begin
    headId      = idMem[rdPtr];
    instrRdata  = memRdata;
    dataRdata   = memRdata;
    instrRvalid = pop && (headId == MST_INSTR);
    dataRvalid  = pop && (headId == MST_DATA);
  end

endmodule

// File: rtl/dual_credit_arbiter.sv
module dual_credit_arbiter
  import credit_arb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CREDIT_W   = 4,
  parameter int PEND_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CREDIT_W-1:0] instrCredit,
  input  logic [CREDIT_W-1:0] dataCredit,
  input  logic [ADDR_W-1:0]   instrAddr,
  input  logic                instrRead,
  output logic                instrWait,
  output logic [DATA_W-1:0]   instrRdata,
  output logic                instrRvalid,
  input  logic [ADDR_W-1:0]   dataAddr,
  input  logic                dataRead,
  input  logic                dataWrite,
  input  logic [DATA_W-1:0]   dataWdata,
  input  logic [DATA_W/8-1:0] dataByteEn,
  output logic                dataWait,
  output logic [DATA_W-1:0]   dataRdata,
  output logic                dataRvalid,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRead,
  output logic                memWrite,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W/8-1:0] memByteEn,
  input  logic                memWait,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                memRvalid
);

  arbStrobe_t strobe;
  logic       fifoFull;

  dca_control #(
    .CREDIT_W (CREDIT_W)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .instrCredit (instrCredit),
    .dataCredit  (dataCredit),
    .instrRead   (instrRead),
    .dataRead    (dataRead),
    .dataWrite   (dataWrite),
    .memWait     (memWait),
    .fifoFull    (fifoFull),
    .strobe      (strobe)
  );

  dca_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PEND_DEPTH (PEND_DEPTH)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .instrAddr   (instrAddr),
    .instrRead   (instrRead),
    .instrWait   (instrWait),
    .instrRdata  (instrRdata),
    .instrRvalid (instrRvalid),
    .dataAddr    (dataAddr),
    .dataRead    (dataRead),
    .dataWrite   (dataWrite),
    .dataWdata   (dataWdata),
    .dataByteEn  (dataByteEn),
    .dataWait    (dataWait),
    .dataRdata   (dataRdata),
    .dataRvalid  (dataRvalid),
    .memAddr     (memAddr),
    .memRead     (memRead),
    .memWrite    (memWrite),
    .memWdata    (memWdata),
    .memByteEn   (memByteEn),
    .memRdata    (memRdata),
    .memRvalid   (memRvalid),
    .fifoFull    (fifoFull)
  );

endmodule

// File: rtl/dca_checker.sv
module dca_checker #(
  parameter int PEND_DEPTH = 8
) (
  input logic clk,
  input logic rstN,
  input logic instrRead,
  input logic instrWait,
  input logic instrRvalid,
  input logic dataRead,
  input logic dataWrite,
  input logic dataWait,
  input logic dataRvalid,
  input logic memRead,
  input logic memWrite,
  input logic memWait,
  input logic memRvalid
);

  localparam int CNT_W = $clog2(PEND_DEPTH + 1) + 1;

  // independent count of reads the slave has taken but not returned
  logic [CNT_W-1:0] seenPend;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      seenPend <= '0;
    else
      seenPend <= seenPend
                  + ((memRead && !memWait) ? CNT_W'(1) : CNT_W'(0))
                  - ((memRvalid && seenPend != '0) ? CNT_W'(1) : CNT_W'(0));
  end

  assert_single_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(!instrWait && !dataWait));

  assert_slave_take_owner_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((memRead || memWrite) && !memWait) |-> (instrWait != dataWait));

  assert_instr_accept_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    !instrWait |-> instrRead);

  assert_data_accept_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    !dataWait |-> (dataRead || dataWrite));

  assert_return_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({instrRvalid, dataRvalid}));

  assert_return_routed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memRvalid && seenPend != '0) |-> (instrRvalid || dataRvalid));

  assert_pend_limit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (seenPend >= CNT_W'(PEND_DEPTH)) |-> !memRead);

endmodule

bind dual_credit_arbiter dca_checker #(
  .PEND_DEPTH (PEND_DEPTH)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .instrRead   (instrRead),
  .instrWait   (instrWait),
  .instrRvalid (instrRvalid),
  .dataRead    (dataRead),
  .dataWrite   (dataWrite),
  .dataWait    (dataWait),
  .dataRvalid  (dataRvalid),
  .memRead     (memRead),
  .memWrite    (memWrite),
  .memWait     (memWait),
  .memRvalid   (memRvalid)
);

// File: tb/dual_credit_arbiter_test.sv
`timescale 1ns/1ps
module dual_credit_arbiter_test;

  localparam int DEPTH = 8;
  localparam int CYCLE_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  instrCredit, dataCredit;
  logic [31:0] instrAddr, dataAddr, dataWdata, memRdata;
  logic        instrRead, dataRead, dataWrite, memWait, memRvalid;
  logic [3:0]  dataByteEn;
  logic        instrWait, instrRvalid, dataWait, dataRvalid, memRead, memWrite;
  logic [31:0] instrRdata, dataRdata, memAddr, memWdata;
  logic [3:0]  memByteEn;

  always #2.5 clk = ~clk;

  dual_credit_arbiter uut (
    .clk(clk), .rstN(rstN), .instrCredit(instrCredit), .dataCredit(dataCredit),
    .instrAddr(instrAddr), .instrRead(instrRead), .instrWait(instrWait),
    .instrRdata(instrRdata), .instrRvalid(instrRvalid),
    .dataAddr(dataAddr), .dataRead(dataRead), .dataWrite(dataWrite),
    .dataWdata(dataWdata), .dataByteEn(dataByteEn), .dataWait(dataWait),
    .dataRdata(dataRdata), .dataRvalid(dataRvalid),
    .memAddr(memAddr), .memRead(memRead), .memWrite(memWrite),
    .memWdata(memWdata), .memByteEn(memByteEn), .memWait(memWait),
    .memRdata(memRdata), .memRvalid(memRvalid)
  );

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
  } dTxn_t;

  typedef struct {
    logic [31:0] addr;
    int          due;
  } slvRd_t;

  logic [31:0] instrQ[$];
  dTxn_t       dataQ[$];
  slvRd_t      slvPipe[$];
  int          idQ[$];
  logic [31:0] instrResp[$];
  logic [31:0] dataResp[$];

  int    nChecks = 0, nErrs = 0, cyc = 0;
  int    slvLat = 2, waitPct = 0;
  string accLog;
  int    maxPend;
  bit    wrWhileFull, stallSeen, timedOut;
  // behavioural arbiter state
  bit    mLocked;
  int    mOwner, mLeft, mLast;

  function automatic logic [31:0] hashOf(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic chkStr(string req, string what, string act, string exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s %s actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  task automatic driveCycle();
    instrRead  = instrQ.size() > 0;
    instrAddr  = instrRead ? instrQ[0] : 32'h0;
    dataRead   = 1'b0;
    dataWrite  = 1'b0;
    dataAddr   = 32'h0;
    dataWdata  = 32'h0;
    dataByteEn = 4'h0;
    if (dataQ.size() > 0) begin
      dataRead   = !dataQ[0].wr;
      dataWrite  = dataQ[0].wr;
      dataAddr   = dataQ[0].addr;
      dataWdata  = dataQ[0].wdata;
      dataByteEn = dataQ[0].be;
    end
    memWait   = (waitPct > 0) && ($urandom_range(0, 99) < waitPct);
    memRvalid = (slvPipe.size() > 0) && (slvPipe[0].due <= cyc);
    memRdata  = memRvalid ? hashOf(slvPipe[0].addr) : 32'h0;
  endtask

  task automatic modelCycle();
    bit reqI, reqD, hold, gv, rd, full, acc;
    int g, base, cfg, pend;
    reqI = instrRead;
    reqD = dataRead || dataWrite;
    pend = idQ.size();
    full = (pend == DEPTH);
    hold = mLocked && ((mOwner == 0) ? reqI : reqD);
    gv   = reqI || reqD;
    if (hold)              g = mOwner;
    else if (reqI && reqD) g = 1 - mLast;   // R6
    else if (reqD)         g = 1;
    else                   g = 0;
    rd  = (g == 0) ? reqI : dataRead;
    acc = gv && !memWait && !(rd && full);

    // R3 / R7: waitrequest low exactly on acceptance
    chk("R3", "instrWait", instrWait, !(acc && g == 0));
    chk("R7", "dataWait", dataWait, !(acc && g == 1));
    // R2 / R9: slave command from the granted master
    chk("R9", "memRead", memRead, gv && rd && !full);
    chk("R2", "memWrite", memWrite, gv && g == 1 && dataWrite);
    if (gv) begin
      chk("R2", "memAddr", memAddr, (g == 0) ? instrAddr : dataAddr);
      chk("R2", "memByteEn", memByteEn, (g == 0) ? 4'hF : dataByteEn);
      if (g == 1 && dataWrite) chk("R2", "memWdata", memWdata, dataWdata);
    end
    // R8: return steering
    if (memRvalid && idQ.size() > 0) begin
      chk("R8", "instrRvalid", instrRvalid, idQ[0] == 0);
      chk("R8", "dataRvalid", dataRvalid, idQ[0] == 1);
      if (idQ[0] == 0) chk("R8", "instrRdata", instrRdata, hashOf(instrResp[0]));
      else             chk("R8", "dataRdata", dataRdata, hashOf(dataResp[0]));
    end else begin
      chk("R8", "rvalid idle", {instrRvalid, dataRvalid}, 2'b00);
    end

    // state the coming edge produces
    if (memRvalid && slvPipe.size() > 0) begin
      void'(slvPipe.pop_front());
      if (idQ.size() > 0) begin
        if (idQ.pop_front() == 0) void'(instrResp.pop_front());
        else                      void'(dataResp.pop_front());
      end
    end
    if (memRead && !memWait) slvPipe.push_back('{memAddr, cyc + slvLat});
    if (gv && rd && full) stallSeen = 1'b1;
    if (acc) begin
      accLog = {accLog, (g == 0) ? "I" : "D"};
      if (g == 0) begin
        instrResp.push_back(instrQ.pop_front());
        idQ.push_back(0);
      end else begin
        dTxn_t t;
        t = dataQ.pop_front();
        if (!t.wr) begin
          dataResp.push_back(t.addr);
          idQ.push_back(1);
        end else if (full) begin
          wrWhileFull = 1'b1;
        end
      end
    end
    if (idQ.size() > maxPend) maxPend = idQ.size();

    // R4 / R5 credit model
    cfg  = (g == 0) ? int'(instrCredit) : int'(dataCredit);
    if (cfg == 0) cfg = 1;
    base = hold ? mLeft : cfg;
    if (!gv) mLocked = 1'b0;
    else if (acc) begin
      mLeft   = base - 1;
      mLocked = (mLeft > 0);
      mOwner  = g;
      mLast   = g;
    end else begin
      mLocked = 1'b1;
      mOwner  = g;
      mLeft   = base;
    end
  endtask

  task automatic runIdle();
    int tail;
    tail = 0;
    while (tail < 3 && !timedOut) begin
      @(negedge clk);
      driveCycle();
      #1;
      modelCycle();
      cyc++;
      if (instrQ.size() > 0 || dataQ.size() > 0 || slvPipe.size() > 0) tail = 0;
      else tail++;
      if (cyc > CYCLE_LIMIT) begin
        timedOut = 1'b1;
        nChecks++;
        nErrs++;
        $display("FAIL watchdog actual=running expected=idle");
      end
    end
    chk("R8", "instr returns outstanding", instrResp.size(), 0);
    chk("R8", "data returns outstanding", dataResp.size(), 0);
  endtask

  task automatic fill(int nI, int nD, bit dWrite, logic [31:0] iBase, logic [31:0] dBase);
    for (int i = 0; i < nI; i++) instrQ.push_back(iBase + 32'(4 * i));
    for (int i = 0; i < nD; i++)
      dataQ.push_back('{dWrite, dBase + 32'(4 * i), 32'hC0DE_0000 + 32'(i), 4'hF});
  endtask

  initial begin
    rstN = 1'b0;
    instrCredit = 4'd1;
    dataCredit  = 4'd1;
    mLocked = 1'b0; mOwner = 0; mLeft = 0; mLast = 1;
    driveCycle();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    driveCycle();
    #1;
    // R1 reset state
    chk("R1", "waits after reset", {instrWait, dataWait}, 2'b11);
    chk("R1", "slave cmd after reset", {memRead, memWrite}, 2'b00);
    chk("R1", "rvalid after reset", {instrRvalid, dataRvalid}, 2'b00);
    cyc++;

    // R10 credit 1: strict alternation, instruction first (R6)
    accLog = ""; fill(8, 8, 1'b0, 32'h0000_1000, 32'h0080_0000);
    runIdle();
    chkStr("R10", "credit-1 order", accLog, "IDIDIDIDIDIDIDID");

    // R10 / R4 credit 8: whole lines
    instrCredit = 4'd8; dataCredit = 4'd8;
    accLog = ""; fill(8, 8, 1'b0, 32'h0000_2000, 32'h0080_1000);
    runIdle();
    chkStr("R4", "credit-8 order", accLog, "IIIIIIIIDDDDDDDD");

    // R4 credit 0 treated as 1, uneven credits
    instrCredit = 4'd0; dataCredit = 4'd3;
    accLog = ""; fill(6, 6, 1'b0, 32'h0000_3000, 32'h0080_2000);
    runIdle();
    chkStr("R4", "credit 0/3 order", accLog, "IDDDIDDDIIII");

    // R5 holder drops request before its credit ends; R6 tie after instr last
    instrCredit = 4'd8; dataCredit = 4'd8;
    accLog = ""; fill(3, 5, 1'b1, 32'h0000_4000, 32'h0080_3000);
    runIdle();
    chkStr("R5", "drop-request order", accLog, "DDDDDIII");

    // mixed traffic with slave stalls (R3, R5, R8)
    instrCredit = 4'd4; dataCredit = 4'd2; waitPct = 40; slvLat = 3;
    for (int i = 0; i < 40; i++) begin
      instrQ.push_back($urandom() & 32'hFFFF_FFFC);
      dataQ.push_back('{bit'($urandom_range(0, 1)), $urandom() & 32'hFFFF_FFFC,
                        $urandom(), 4'($urandom_range(1, 15))});
    end
    accLog = "";
    runIdle();
    chk("R3", "mixed accepted count", accLog.len(), 80);

    // R9 pending-read limit with long slave latency
    waitPct = 0; slvLat = 14; dataCredit = 4'd12;
    maxPend = 0; wrWhileFull = 1'b0; stallSeen = 1'b0;
    fill(0, 8, 1'b0, 32'h0000_0000, 32'h0090_0000);
    dataQ.push_back('{1'b1, 32'h0091_0000, 32'h1234_5678, 4'h3});
    fill(0, 2, 1'b0, 32'h0000_0000, 32'h0092_0000);
    runIdle();
    chk("R9", "max pending reads", maxPend, DEPTH);
    chk("R9", "read held off when full", stallSeen, 1'b1);
    chk("R9", "write accepted while full", wrWhileFull, 1'b1);

    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule